// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block keeps the per-pad setup and value state for a parameterised group of general-purpose pads. Software reaches it through a flat memory-mapped register port. Each pad owns a 16-byte window. That window holds three words:

- a configuration word, with the function select, trigger flags, pull settings and open-drain flag;
- an auxiliary configuration word, stored as it is written;
- a value word, with active-low output and input enables and the level bit.

On the pad side, the block drives an output level and an output enable for every pad. It samples every pad input through a two-flop synchroniser. A pad is driven only when its function-select field equals that pad's GPIO function code, which is set by parameter. In open-drain mode, the pad is pulled low while the level bit is 0 and released while it is 1. Pull settings and trigger flags are only stored, for use by neighbouring logic.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset, every configuration and auxiliary word reads 0, every value word reads 0x6 (both enables inactive, level 0), and every pad output enable is 0.
- R2: Pad n's words sit at byte address n*16: configuration at +0x0, auxiliary at +0x4, value at +0x8. A write changes only the addressed word. Address +0xC reads 0, and writes to it are ignored.
- R3: The configuration word keeps bits 2:0 (function select), 8:7 (pull direction, 1 = up, 2 = down), 10:9 (pull strength code), 24 (level trigger), 25 (rising/high), 26 (falling/low), 27 (direct interrupt) and 31 (open drain). All other bits read 0.
- R4: The value word keeps bit 0 (level), bit 1 (output enable, 0 = enabled) and bit 2 (input enable, 0 = enabled). Bits 31:3 read 0.
- R5: With the output enabled, the function matching and open drain off, pad_oe is 1 and pad_out equals the level bit from the clock edge that stores the write. A read-modify-write of the level alone updates the pad.
- R6: Bit 0 of a value read returns the stored level when the output is enabled or both enables are off. It returns the synchronised pad input when only the input is enabled.
- R7: A change on pad_in becomes visible in bit 0 after exactly two rising clock edges, and not after one.
- R8: With open drain set (configuration bit 31), pad_oe is 1 only while the level bit is 0, and pad_out is then 0.
- R9: When a pad's function-select field differs from that pad's function code (parameter GPIO_FUNC_CODES, 3 bits per pad, pad n at bits 3n+2:3n), pad_oe is held at 0.
- R10: The auxiliary configuration word stores and returns all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to clk on release |
| reg_wr_en | input | 1 | Write strobe, one word per cycle |
| reg_addr | input | ADDR_W | Byte address (pad index above bit 4, word at bits 3:2) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pad_in | input | NUM_PADS | Asynchronous pad input levels |
| pad_out | output | NUM_PADS | Level driven onto each pad |
| pad_oe | output | NUM_PADS | Pad output enable, 1 = driving |

## Verification
The drive path is tried in four configurations: output enabled, input only, both enables off, and open drain. In each case the pad is held at a level opposite to the stored bit, so a read of bit 0 shows which source the block selected. The function-select test uses one pad with code 0 and one with code 1, so that matching on a hardwired zero cannot pass. The synchroniser test samples after one edge and again after two, which separates a two-flop path from a one-flop or a three-flop path. Writes of all ones, and of patterns placed at field boundaries, expose any bit that is stored when it should read 0 or lost when it should be kept.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int DATA_W      = 32;
  localparam int WIN_LSB     = 4;       // 16-byte window per pad
  localparam logic [1:0] WSEL_CONF  = 2'd0;
  localparam logic [1:0] WSEL_AUX   = 2'd1;
  localparam logic [1:0] WSEL_VALUE = 2'd2;

  // value word
  localparam int LVL_BIT  = 0;
  localparam int OEN_BIT  = 1;
  localparam int IEN_BIT  = 2;
  localparam logic [DATA_W-1:0] VALUE_KEEP = 32'h0000_0007;
  localparam logic [DATA_W-1:0] VALUE_RST  = 32'h0000_0006;

  // configuration word
  localparam int FSEL_LSB = 0;
  localparam int FSEL_W   = 3;
  localparam int OD_BIT   = 31;
  localparam logic [DATA_W-1:0] CONF_KEEP = 32'h8F00_0787;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpb_pad_cell.sv
module gpb_pad_cell
  import gpb_pkg::*;
#(
  parameter logic [FSEL_W-1:0] FUNC_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_conf,
  input  logic              wr_aux,
  input  logic              wr_value,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pin_sync,
  output logic [DATA_W-1:0] conf_rd,
  output logic [DATA_W-1:0] aux_rd,
  output logic [DATA_W-1:0] value_rd,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              od_mode,
  output logic              func_ok
);
  logic [DATA_W-1:0] conf_q, conf_d;
  logic [DATA_W-1:0] aux_q, aux_d;
  logic [DATA_W-1:0] val_q, val_d;

  // next state with explicit enables
  always_comb begin
    conf_d = conf_q;
    aux_d  = aux_q;
    val_d  = val_q;
    if (wr_conf)  conf_d = wdata & CONF_KEEP;
    if (wr_aux)   aux_d  = wdata;
    if (wr_value) val_d  = wdata & VALUE_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conf_q <= '0;
      aux_q  <= '0;
      val_q  <= VALUE_RST;
    end else begin
      conf_q <= conf_d;
      aux_q  <= aux_d;
      val_q  <= val_d;
    end
  end

  logic out_on, in_only;
  assign out_on  = !val_q[OEN_BIT];
  assign in_only = val_q[OEN_BIT] && !val_q[IEN_BIT];
  assign od_mode = conf_q[OD_BIT];
  assign func_ok = (conf_q[FSEL_LSB +: FSEL_W] == FUNC_CODE);

  always_comb begin
    value_rd = val_q;
    if (in_only) value_rd[LVL_BIT] = pin_sync;
  end

  assign conf_rd = conf_q;
  assign aux_rd  = aux_q;
  assign pad_out = od_mode ? 1'b0 : val_q[LVL_BIT];
  assign pad_oe  = func_ok && out_on && (!od_mode || !val_q[LVL_BIT]);
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpb_pkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter logic [NUM_PADS*FSEL_W-1:0] GPIO_FUNC_CODES = '0,
  localparam int PAD_IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1,
  localparam int ADDR_W    = PAD_IDX_W + WIN_LSB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);
  logic [PAD_IDX_W-1:0] pad_sel;
  logic [1:0]           word_sel;
  assign pad_sel  = reg_addr[ADDR_W-1:WIN_LSB];
  assign word_sel = reg_addr[3:2];

  logic [NUM_PADS-1:0] pin_sync;
  logic [NUM_PADS-1:0] od_vec;
  logic [NUM_PADS-1:0] func_ok_vec;
  logic [DATA_W-1:0]   conf_rd  [NUM_PADS];
  logic [DATA_W-1:0]   aux_rd   [NUM_PADS];
  logic [DATA_W-1:0]   value_rd [NUM_PADS];

  gpb_sync #(.W(NUM_PADS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic hit;
    assign hit = reg_wr_en && (pad_sel == PAD_IDX_W'(p));

    gpb_pad_cell #(
      .FUNC_CODE (GPIO_FUNC_CODES[p*FSEL_W +: FSEL_W])
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_conf  (hit && word_sel == WSEL_CONF),
      .wr_aux   (hit && word_sel == WSEL_AUX),
      .wr_value (hit && word_sel == WSEL_VALUE),
      .wdata    (reg_wdata),
      .pin_sync (pin_sync[p]),
      .conf_rd  (conf_rd[p]),
      .aux_rd   (aux_rd[p]),
      .value_rd (value_rd[p]),
      .pad_out  (pad_out[p]),
      .pad_oe   (pad_oe[p]),
      .od_mode  (od_vec[p]),
      .func_ok  (func_ok_vec[p])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (pad_sel == PAD_IDX_W'(p)) begin
        case (word_sel)
          WSEL_CONF:  reg_rdata = conf_rd[p];
          WSEL_AUX:   reg_rdata = aux_rd[p];
          WSEL_VALUE: reg_rdata = value_rd[p];
          default:    reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker
  import gpb_pkg::*;
#(
  parameter int NUM_PADS  = 4,
  parameter int PAD_IDX_W = 2,
  parameter int ADDR_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr_en,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [NUM_PADS-1:0] pad_oe,
  input logic [NUM_PADS-1:0] od_vec,
  input logic [NUM_PADS-1:0] func_ok_vec
);
  logic [PAD_IDX_W-1:0] wpad;
  logic                 wr_val;
  logic                 in_range;
  assign wpad     = reg_addr[ADDR_W-1:WIN_LSB];
  assign in_range = (int'(wpad) < NUM_PADS);
  assign wr_val   = reg_wr_en && in_range && (reg_addr[3:2] == WSEL_VALUE);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0));

  // R4
  value_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_range && reg_addr[3:2] == WSEL_VALUE) |-> (reg_rdata[DATA_W-1:3] == '0));

  // R5
  drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_val && !reg_wdata[OEN_BIT] && func_ok_vec[wpad] && !od_vec[wpad])
    |=> (pad_oe[$past(wpad)] && pad_out[$past(wpad)] == $past(reg_wdata[LVL_BIT])));

  // R8
  open_drain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & od_vec & pad_out) == '0));

  // R9
  func_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~func_ok_vec) == '0));
endmodule

bind gpio_pad_bank gpb_checker #(
  .NUM_PADS  (NUM_PADS),
  .PAD_IDX_W (PAD_IDX_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .od_vec      (od_vec),
  .func_ok_vec (func_ok_vec)
);

// File: tb/tb_gpio_pad_bank.sv
`timescale 1ns/1ps
module tb_gpio_pad_bank;
  localparam int N  = 4;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr_en;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  pad_in;
  logic [N-1:0]  pad_out;
  logic [N-1:0]  pad_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // pad 1 uses function code 1, the others code 0
  gpio_pad_bank #(.NUM_PADS(N), .GPIO_FUNC_CODES(12'h008)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] adr(input int pad, input int off);
    return AW'(pad * 16 + off);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(adr(0, 0), d); chk("R1 conf", d, 32'h0);
    rd(adr(3, 4), d); chk("R1 aux", d, 32'h0);
    rd(adr(2, 8), d); chk("R1 value", d, 32'h6);
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(adr(2, 0), 32'hFFFF_FFFF);
    rd(adr(2, 0), d); chk("R3 conf keep mask", d, 32'h8F00_0787);
    wr(adr(2, 0), 32'h0200_0483);   // func 3, pull up, strength 2, rising
    rd(adr(2, 0), d); chk("R3 conf fields", d, 32'h0200_0483);
    wr(adr(2, 4), 32'h1234_5678);
    rd(adr(2, 4), d); chk("R10 aux all bits", d, 32'h1234_5678);
    rd(adr(2, 8), d); chk("R2 neighbour value kept", d, 32'h6);
    rd(adr(3, 0), d); chk("R2 other pad conf kept", d, 32'h0);
    wr(adr(1, 12), 32'hFFFF_FFFF);
    rd(adr(1, 12), d); chk("R2 hole reads zero", d, 32'h0);
    rd(adr(1, 0), d); chk("R2 hole write ignored", d, 32'h0);
  endtask

  task automatic t_value_word();
    logic [31:0] d;
    wr(adr(3, 8), 32'hFFFF_FFF8);
    rd(adr(3, 8), d); chk("R4 upper bits zero", d, 32'h0);
    chk("R5 pad3 oe", 32'(pad_oe[3]), 32'h1);
    chk("R5 pad3 out low", 32'(pad_out[3]), 32'h0);
  endtask

  task automatic t_drive();
    logic [31:0] d;
    pad_in[0] = 1'b0;
    wr(adr(0, 8), 32'h1);
    chk("R5 oe after write", 32'(pad_oe[0]), 32'h1);
    chk("R5 out after write", 32'(pad_out[0]), 32'h1);
    rd(adr(0, 8), d); chk("R6 out-enabled reads stored level", d, 32'h1);
    wr(adr(0, 8), d & ~32'h1);
    chk("R5 rmw level", 32'(pad_out[0]), 32'h0);
    chk("R5 rmw oe kept", 32'(pad_oe[0]), 32'h1);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    wr(adr(0, 8), 32'h2);            // input only, stored level 0
    repeat (3) @(posedge clk);
    @(negedge clk); pad_in[0] = 1'b1;
    @(posedge clk);
    rd(adr(0, 8), d); chk("R7 not after one edge", d, 32'h2);
    // rd waited for the next negedge, after which the second edge follows
    @(posedge clk);
    rd(adr(0, 8), d); chk("R7 after two edges", d, 32'h3);
    chk("R6 input-only pad oe off", 32'(pad_oe[0]), 32'h0);
    wr(adr(0, 8), 32'h6);
    rd(adr(0, 8), d); chk("R6 both off reads stored", d, 32'h6);
  endtask

  task automatic t_open_drain();
    wr(adr(0, 0), 32'h8000_0000);
    wr(adr(0, 8), 32'h1);
    chk("R8 released at level 1", 32'(pad_oe[0]), 32'h0);
    wr(adr(0, 8), 32'h0);
    chk("R8 driven at level 0", 32'(pad_oe[0]), 32'h1);
    chk("R8 drives low", 32'(pad_out[0]), 32'h0);
    wr(adr(0, 0), 32'h0);
  endtask

  task automatic t_func();
    wr(adr(0, 0), 32'h1);
    chk("R9 pad0 code mismatch", 32'(pad_oe[0]), 32'h0);
    wr(adr(1, 8), 32'h1);
    chk("R9 pad1 code 0 mismatch", 32'(pad_oe[1]), 32'h0);
    wr(adr(1, 0), 32'h1);
    chk("R9 pad1 code 1 match", 32'(pad_oe[1]), 32'h1);
    chk("R9 pad1 level", 32'(pad_out[1]), 32'h1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0; pad_in = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_map();
    t_value_word();
    t_drive();
    t_sync();
    t_open_drain();
    t_func();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule